// File: doc/BRIEF.md
# Urgency-Driven Thread Switch Controller

This block decides which of two hardware thread contexts owns a coarse-grained multithreaded pipeline. Each thread has a 3-bit urgency register. Events change it: a blocking long-latency miss lowers it, returned miss data raises it again, an external interrupt lifts it, and a fairness timer lifts it further. The controller compares the urgency of the foreground thread against the urgency of the background thread. When the foreground value is strictly lower, it hands the pipeline to the other thread.

The pipeline sees two outputs: the current active thread ID, and a one-cycle pulse that starts the flush. A software switch hint forces a handover. A minimum hold window after each switch keeps the pipeline from changing threads again while the flush penalty is still being paid. The fairness timer reloads from a programmable limit input on every switch. If the foreground thread keeps the pipeline too long, the timer raises the waiting thread to the top urgency.

Top module: `tsw_ctrl`

## Requirements
- R1: During and straight after reset, `active_tid` is 0, `switch_pulse` is 0, and both urgency fields of `urg_level` are 5. Bits [2:0] hold thread 0 and bits [5:3] hold thread 1.
- R2: A cycle with `miss_evt[t]` high and no higher-priority event for thread t lowers that thread's urgency by one at the next edge. At 0 the urgency stays at 0.
- R3: A cycle with `fill_evt[t]` high and no higher-priority event raises that thread's urgency by one when it is below 5. At 5, 6 or 7 the fill has no effect.
- R4: `irq_evt[t]` sets thread t's urgency to 6 at the next edge, unless a timeout hits the same thread in that cycle.
- R5: The timeout counter loads `tmo_limit` at reset, on every switch and on every expiry, and counts down by one per cycle otherwise. In the cycle it reads 0 it expires: the background thread's urgency becomes 7 at that edge. With no switch, expiries fall every `tmo_limit`+1 cycles.
- R6: Priority per thread within one cycle is timeout, then interrupt, then miss/fill. A miss and a fill on the same thread in the same cycle leave the urgency unchanged.
- R7: When the hold window is clear and the foreground urgency, as registered before the edge, is strictly less than the background urgency, a switch takes place at that edge. Equal urgencies never cause a switch.
- R8: `switch_hint` high while the hold window is clear forces a switch at that edge, whatever the urgencies are.
- R9: On a switch, `active_tid` toggles and `switch_pulse` is high for exactly the one cycle in which the new ID first shows.
- R10: After a switch, at least `HOLD_CYC` (default 4) cycles with `switch_pulse` low pass before the next pulse. Hints and urgency requests in that window are ignored. An urgency request still pending when the window ends is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_limit | input | TMO_W | Reload value of the fairness timeout counter |
| irq_evt | input | 2 | Per-thread external interrupt event |
| miss_evt | input | 2 | Per-thread blocking long-latency miss event |
| fill_evt | input | 2 | Per-thread miss data return event |
| switch_hint | input | 1 | Request to hand the pipeline to the other thread |
| active_tid | output | 1 | ID of the foreground thread |
| switch_pulse | output | 1 | One-cycle flush request on each switch |
| urg_level | output | 6 | Urgency of thread 1 (bits 5:3) and thread 0 (bits 2:0) |

## Verification
The timeout expiry can land in the same cycle as an interrupt or a miss aimed at the waiting thread. In that cycle the urgency must go to 7 and not to 6 or one lower. The bench provokes this by holding interrupts and misses on both threads for a long stretch under a short timeout limit, so expiries are bound to coincide with them. A cycle-accurate reference model built from the requirements predicts every output. Thread ID, pulse and both urgency fields are compared after each edge, so a wrong priority order shows as a wrong urgency value in that one cycle.

// File: rtl/tsw_pkg.sv
// Shared types and urgency constants for the thread switch controller.
// Assumes exactly two thread contexts and 3-bit urgency levels.
package tsw_pkg;
    localparam int NUM_THR = 2;
    localparam int URG_W   = 3;
    typedef logic [URG_W-1:0] urg_t;
    localparam urg_t URG_TOP = 3'd7;   // fairness timeout level
    localparam urg_t URG_INT = 3'd6;   // external interrupt level
    localparam urg_t URG_NOM = 3'd5;   // nominal progress level
endpackage

// File: rtl/tsw_urgency.sv
// Urgency register for one thread context.
// Applies the events of one cycle in fixed priority: timeout, interrupt,
// then miss/fill. Assumes at most one event of each kind per cycle.
module tsw_urgency
    import tsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_hit,
    input  logic irq,
    input  logic miss,
    input  logic fill,
    output urg_t level
);
    urg_t lvl_q;

    // Update the urgency level from this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= URG_NOM;
        end else if (tmo_hit) begin
            lvl_q <= URG_TOP;
        end else if (irq) begin
            lvl_q <= URG_INT;
        end else if (miss && !fill) begin
            lvl_q <= (lvl_q == '0) ? '0 : lvl_q - 3'd1;
        end else if (fill && !miss && (lvl_q < URG_NOM)) begin
            lvl_q <= lvl_q + 3'd1;
        end
    end

    assign level = lvl_q;

    AST_TMO_TOP:   assert property (@(posedge clk) disable iff (!rst_n) tmo_hit |=> lvl_q == URG_TOP); // R5
    AST_IRQ_SET:   assert property (@(posedge clk) disable iff (!rst_n) (irq && !tmo_hit) |=> lvl_q == URG_INT); // R4
    AST_SAT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (lvl_q == '0 && miss && !irq && !tmo_hit) |=> lvl_q == '0); // R2
    AST_FILL_CAP:  assert property (@(posedge clk) disable iff (!rst_n) (fill && !miss && !irq && !tmo_hit && lvl_q >= URG_NOM) |=> $stable(lvl_q)); // R3
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fill && miss && !irq && !tmo_hit) |=> $stable(lvl_q)); // R6
endmodule

// File: rtl/tsw_timer.sv
// Fairness timeout counter.
// Loads the limit at reset, on reload and on expiry; expires while at zero.
// Assumes the limit input is stable around reload edges.
module tsw_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    assign expire = (cnt_q == '0);

    // Count down the foreground residency, restarting on switch or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || reload || expire) begin
            cnt_q <= limit;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TMO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) reload |=> cnt_q == $past(limit)); // R5
endmodule

// File: rtl/tsw_arbiter.sv
// Switch decision and foreground thread register.
// Switches on a hint or when foreground urgency is below background urgency,
// but only once the post-switch hold window has drained.
module tsw_arbiter
    import tsw_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    localparam int HOLD_W = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  urg_t urg_fg,
    input  urg_t urg_bg,
    input  logic hint,
    output logic take,
    output logic active,
    output logic pulse
);
    logic [HOLD_W-1:0] hold_q;
    logic              want;

    // Form the switch request and gate it with the hold window.
    always_comb begin
        want = hint || (urg_fg < urg_bg);
        take = (hold_q == '0) && want;
    end

    // Track the foreground thread, the flush pulse and the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pulse  <= 1'b0;
            hold_q <= '0;
        end else begin
            pulse <= take;
            if (take) begin
                active <= ~active;
                hold_q <= HOLD_W'(HOLD_CYC);
            end else if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    AST_HINT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (hint && hold_q == '0) |=> pulse); // R8
    AST_CMP_SWITCH: assert property (@(posedge clk) disable iff (!rst_n) (hold_q == '0 && urg_fg < urg_bg) |=> pulse); // R7
endmodule

// File: rtl/tsw_ctrl.sv
// Top of the two-context thread switch controller.
// Holds one urgency unit per thread, the fairness timer and the arbiter.
// The timer expiry raises the background thread; the pipeline flush and
// context storage live outside this block.
module tsw_ctrl
    import tsw_pkg::*;
#(
    parameter int TMO_W    = 8,
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [1:0]       irq_evt,
    input  logic [1:0]       miss_evt,
    input  logic [1:0]       fill_evt,
    input  logic             switch_hint,
    output logic             active_tid,
    output logic             switch_pulse,
    output logic [5:0]       urg_level
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    urg_t urg_q [NUM_THR];
    logic expire;
    logic take;
    urg_t urg_fg;
    urg_t urg_bg;

    // One urgency unit per thread; the timeout only targets the waiting one.
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        tsw_urgency u_urg (
            .clk     (clk),
            .rst_n   (rst_n),
            .tmo_hit (expire && (active_tid != 1'(t))),
            .irq     (irq_evt[t]),
            .miss    (miss_evt[t]),
            .fill    (fill_evt[t]),
            .level   (urg_q[t])
        );
        assign urg_level[t*URG_W +: URG_W] = urg_q[t];
    end

    // Select foreground and background urgency for the comparison.
    always_comb begin
        urg_fg = urg_q[active_tid];
        urg_bg = urg_q[~active_tid];
    end

    tsw_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (take),
        .limit  (tmo_limit),
        .expire (expire)
    );

    tsw_arbiter #(.HOLD_CYC(HOLD_CYC)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .urg_fg (urg_fg),
        .urg_bg (urg_bg),
        .hint   (switch_hint),
        .take   (take),
        .active (active_tid),
        .pulse  (switch_pulse)
    );

    // Count pulse-free cycles since the last switch, for the hold check.
    logic [HOLD_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                       gap_q <= HOLD_W'(HOLD_CYC);
        else if (switch_pulse)            gap_q <= '0;
        else if (gap_q < HOLD_W'(HOLD_CYC)) gap_q <= gap_q + 1'b1;
    end

    AST_PULSE_FLIP:   assert property (@(posedge clk) disable iff (!rst_n) switch_pulse |-> active_tid != $past(active_tid)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) switch_pulse |=> !switch_pulse); // R9
    AST_HOLD_GAP:     assert property (@(posedge clk) disable iff (!rst_n) switch_pulse |-> gap_q >= HOLD_W'(HOLD_CYC)); // R10
endmodule

// File: tb/tsw_ctrl_tb.sv
`timescale 1ns/1ps
module tsw_ctrl_tb;
    localparam int TMO_W = 8;
    localparam int HOLD  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd40;
    logic [1:0]       irq_evt = '0, miss_evt = '0, fill_evt = '0;
    logic             switch_hint = 1'b0;
    logic             active_tid, switch_pulse;
    logic [5:0]       urg_level;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tsw_ctrl #(.TMO_W(TMO_W), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .irq_evt(irq_evt), .miss_evt(miss_evt), .fill_evt(fill_evt),
        .switch_hint(switch_hint), .active_tid(active_tid),
        .switch_pulse(switch_pulse), .urg_level(urg_level)
    );

    // Reference model state, derived from the requirements.
    logic       m_act;
    logic [2:0] m_urg [2];
    int         m_tmo;
    int         m_hold;

    // Scoreboard queues: packed {act, pulse, urg1, urg0} and the requirement tag.
    logic [7:0] q_val [$];
    string      q_tag [$];

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, advance the model, push the expectation.
    task automatic step(input logic [1:0] irq, input logic [1:0] miss,
                        input logic [1:0] fill, input logic hint, input string tag);
        logic exp_hit, sw;
        logic [2:0] nu [2];
        irq_evt = irq; miss_evt = miss; fill_evt = fill; switch_hint = hint;
        exp_hit = (m_tmo == 0);
        sw = (m_hold == 0) && (hint || (m_urg[m_act] < m_urg[!m_act]));
        for (int t = 0; t < 2; t++) begin
            nu[t] = m_urg[t];
            if (exp_hit && (t != int'(m_act)))   nu[t] = 3'd7;
            else if (irq[t])                     nu[t] = 3'd6;
            else if (miss[t] && !fill[t])        nu[t] = (m_urg[t] == 0) ? 3'd0 : m_urg[t] - 3'd1;
            else if (fill[t] && !miss[t] && m_urg[t] < 3'd5) nu[t] = m_urg[t] + 3'd1;
        end
        m_tmo  = (sw || exp_hit) ? int'(tmo_limit) : m_tmo - 1;
        m_hold = sw ? HOLD : ((m_hold > 0) ? m_hold - 1 : 0);
        m_act  = m_act ^ sw;
        m_urg[0] = nu[0];
        m_urg[1] = nu[1];
        q_val.push_back({m_act, sw, nu[1], nu[0]});
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(2'b00, 2'b00, 2'b00, 1'b0, tag);
    endtask

    // Monitor: after each edge, pop one expectation and compare all outputs.
    always @(posedge clk) begin
        #1;
        if (q_val.size() > 0) begin
            logic [7:0] e;
            string tg;
            e  = q_val.pop_front();
            tg = q_tag.pop_front();
            chk(active_tid == e[7], tg, "active_tid", int'(active_tid), int'(e[7]));
            chk(switch_pulse == e[6], tg, "switch_pulse", int'(switch_pulse), int'(e[6]));
            chk(urg_level[2:0] == e[2:0], tg, "urg thread0", int'(urg_level[2:0]), int'(e[2:0]));
            chk(urg_level[5:3] == e[5:3], tg, "urg thread1", int'(urg_level[5:3]), int'(e[5:3]));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_act = 1'b0; m_urg[0] = 3'd5; m_urg[1] = 3'd5; m_tmo = 40; m_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible before any post-reset edge.
        chk(active_tid == 1'b0, "R1", "active_tid", int'(active_tid), 0);
        chk(switch_pulse == 1'b0, "R1", "switch_pulse", int'(switch_pulse), 0);
        chk(urg_level == 6'b101_101, "R1", "urg_level", int'(urg_level), 45);

        idle(5, "R7");                                  // equal urgencies: no switch
        step(2'b00, 2'b01, 2'b00, 1'b0, "R2");          // miss on foreground thread 0
        step(2'b00, 2'b00, 2'b00, 1'b0, "R7");          // 4 < 5: switch
        step(2'b00, 2'b00, 2'b00, 1'b1, "R10");         // hint inside hold: ignored
        idle(6, "R9");
        step(2'b00, 2'b00, 2'b00, 1'b1, "R8");          // hint with hold clear
        idle(8, "R10");                                 // pending urgency request after hold
        step(2'b00, 2'b00, 2'b01, 1'b0, "R3");          // fill raises thread 0
        step(2'b00, 2'b00, 2'b01, 1'b0, "R3");          // fill at 5: no effect
        step(2'b10, 2'b00, 2'b00, 1'b0, "R4");          // interrupt thread 1
        step(2'b00, 2'b00, 2'b10, 1'b0, "R3");          // fill at 6: no effect
        idle(6, "R7");
        for (int i = 0; i < 9; i++) step(2'b00, 2'b10, 2'b00, 1'b0, "R2"); // drain to 0 and saturate
        idle(8, "R7");
        step(2'b00, 2'b11, 2'b11, 1'b0, "R6");          // miss and fill together
        step(2'b01, 2'b01, 2'b00, 1'b0, "R6");          // interrupt beats miss
        for (int i = 0; i < 6; i++) step(2'b00, 2'b00, 2'b11, 1'b0, "R3");
        idle(100, "R5");                                // timeout expiries
        tmo_limit = 8'd7;
        idle(30, "R5");
        for (int i = 0; i < 60; i++) step(2'b11, 2'b11, 2'b00, 1'b0, "R6"); // timeout vs interrupt
        for (int i = 0; i < 40; i++) step(2'b00, {i[0], ~i[0]}, 2'b00, i[2], "R10");
        idle(20, "R5");
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule